// File: doc/BRIEF.md
# ATA PIO Sector Transfer Sequencer

This block is a host-side engine that moves whole sectors between a system and an ATA-style drive using programmed I/O. One request carries an operation (read, write or presence probe), a 28-bit logical block address, a sector count and a drive select. The sequencer waits for the drive to become ready. It then programs the task-file registers in a fixed order and issues the command. For each sector it waits for readiness again, checks the fault bits, and moves the sector's 32-bit words through the data register.

Task-file traffic uses a simple single-cycle register bus. Each access is a read strobe or a write strobe, with a 4-bit address. Addresses 0 to 7 select the command block. Address 0xE selects the device control register. Read data is returned combinationally in the cycle of the strobe. Sector data leaves on a valid/ready read stream and arrives on a valid/ready write stream. Completion is a one-cycle `done` pulse that carries a failure flag, a failure cause and, for probes, the presence result.

Top module: `ata_pio_seq`

## Requirements
- R1: A status read is a read strobe at address 7. The drive counts as ready only when status AND 0xC0 equals 0x40, so BSY (0x80) must be clear and DRDY (0x40) set. No task-file write happens before that wait succeeds.
- R2: A read writes 0x00 to the device control register (address 0xE) after the first readiness wait and before any task-file write. A write skips this access.
- R3: The command is programmed in consecutive cycles in this order: count at address 2, LBA[7:0] at 3, LBA[15:8] at 4, LBA[23:16] at 5, drive/head at 6, command at 7.
- R4: The drive/head byte is 0xE0 OR (drive << 4) OR LBA[27:24]. The command byte is 0x20 for a read (op 0) and 0x30 for a write (op 1).
- R5: A count of 256 is written as 0x00 into the count register.
- R6: A count of 0, a count above 256, or op code 3 is rejected without any bus access. It ends with `done`, `fail` set and cause 3.
- R7: Before every sector the status is polled again until ready. Each sector then makes exactly 128 data accesses at address 0.
- R8: Read words leave on the read stream in bus order. While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold.
- R9: Write words are taken from the write stream, one per `wr_valid`/`wr_ready` handshake, and written to address 0 in arrival order.
- R10: If DF (0x20) or ERR (0x01) is set in the ready status of a per-sector wait, the transfer stops with no further bus access and cause 1. The wait before the command ignores both bits.
- R11: If POLL_LIMIT consecutive status reads in one readiness wait are all not ready, the request ends with cause 2 and polling stops.
- R12: A probe (op 2) waits for readiness and writes 0xF0 to address 6. It then reads status up to PROBE_LIMIT times until it sees a nonzero value, writes 0xE0 to address 6, and reports `present` as 1 if a nonzero status was seen.
- R13: `req_ready` is high only while idle. `done` lasts exactly one cycle. Cause 0 means success, and `fail` is high exactly when the cause is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | 0 read, 1 write, 2 probe, 3 invalid |
| req_lba | input | 28 | Logical block address |
| req_count | input | 9 | Sectors to move, 1 to 256 |
| req_drive | input | 1 | Drive select |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Request failed, valid with done |
| fail_cause | output | 2 | 0 none, 1 device fault, 2 timeout, 3 bad request |
| present | output | 1 | Probe result, valid with done |
| rb_addr | output | 4 | Register bus address |
| rb_wdata | output | 32 | Register bus write data |
| rb_wr | output | 1 | Register write strobe |
| rb_rd | output | 1 | Register read strobe |
| rb_rdata | input | 32 | Register read data, same cycle as rb_rd |
| rd_valid | output | 1 | Read stream word valid |
| rd_ready | input | 1 | Read stream consumer ready |
| rd_data | output | 32 | Read stream word |
| wr_valid | input | 1 | Write stream word valid |
| wr_ready | output | 1 | Write stream sequencer ready |
| wr_data | input | 32 | Write stream word |

## Verification
Most internal faults show up on the register bus within a cycle or two. A wrong step index or state shows as a write to the wrong address or with the wrong byte. A bad word or sector counter shows as an access missing or extra at the end of a sector, at the latest after 128 words. A wrong ready or fault decision shows in the first status read that follows it: the block either polls too long or moves on too early. The bench compares every bus strobe against an expected access list built from the requirements, so the first wrong access is reported in the cycle it occurs. Stream words and completion fields are checked as they appear.

// File: rtl/ata_seq_pkg.sv
// Shared types and constants for the PIO sector sequencer.
// Assumes a 4-bit register address: 0..7 command block, 0xE device control.
package ata_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PROBE = 2'd2,
        OP_BAD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_DEVICE  = 2'd1,
        CAUSE_TIMEOUT = 2'd2,
        CAUSE_REQUEST = 2'd3
    } cause_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PREWAIT,
        S_CTRL,
        S_TASK,
        S_SECWAIT,
        S_RDBUS,
        S_RDOUT,
        S_WRXFER,
        S_PRBWAIT,
        S_PRBSEL,
        S_PRBPOLL,
        S_PRBDESEL,
        S_FINISH
    } state_e;

    localparam logic [7:0] ST_BSY  = 8'h80;
    localparam logic [7:0] ST_DRDY = 8'h40;
    localparam logic [7:0] ST_DF   = 8'h20;
    localparam logic [7:0] ST_ERR  = 8'h01;

    localparam logic [3:0] ADDR_DATA   = 4'h0;
    localparam logic [3:0] ADDR_COUNT  = 4'h2;
    localparam logic [3:0] ADDR_LBA0   = 4'h3;
    localparam logic [3:0] ADDR_LBA1   = 4'h4;
    localparam logic [3:0] ADDR_LBA2   = 4'h5;
    localparam logic [3:0] ADDR_DRVHD  = 4'h6;
    localparam logic [3:0] ADDR_CMDST  = 4'h7;
    localparam logic [3:0] ADDR_DEVCTL = 4'hE;

    localparam logic [7:0] CMD_RD_SECT = 8'h20;
    localparam logic [7:0] CMD_WR_SECT = 8'h30;
    localparam logic [7:0] DRVHD_BASE  = 8'hE0;

endpackage

// File: rtl/ata_status_eval.sv
// Status evaluator with a bounded poll counter.
// MATCH_READY=1: a hit is (status & (BSY|DRDY)) == DRDY.
// MATCH_READY=0: a hit is any nonzero status (presence probe).
// Assumes the caller polls in consecutive cycles; the counter clears whenever poll is low.
module ata_status_eval
    import ata_seq_pkg::*;
#(
    parameter int LIMIT       = 1000,
    parameter bit MATCH_READY = 1'b1,
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       poll,
    input  logic [7:0] status,
    output logic       hit,
    output logic       fault,
    output logic       expired
);

    logic [CW-1:0] miss_cnt;

    // Select the hit rule for this instance.
    generate
        if (MATCH_READY) begin : g_ready
            assign hit = (status & (ST_BSY | ST_DRDY)) == ST_DRDY;
        end else begin : g_nonzero
            assign hit = status != 8'h00;
        end
    endgenerate

    assign fault   = (status & (ST_DF | ST_ERR)) != 8'h00;
    assign expired = poll && !hit && (miss_cnt == CW'(LIMIT - 1));

    // Count consecutive misses within one polling run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_cnt <= '0;
        end else if (!poll || hit || expired) begin
            miss_cnt <= '0;
        end else begin
            miss_cnt <= miss_cnt + 1'b1;
        end
    end

    // R11: once the limit is reached the caller stops polling.
    assert_poll_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !poll);

endmodule

// File: rtl/ata_taskfile_enc.sv
// Task-file encoder: maps a programming step (0..5) to a register address and byte.
// The step order is the issue order: count, LBA low/mid/high, drive/head, command.
module ata_taskfile_enc
    import ata_seq_pkg::*;
(
    input  logic [2:0]  step,
    input  logic [7:0]  count_lo,
    input  logic [27:0] lba,
    input  logic        drive,
    input  logic        is_write,
    output logic [3:0]  addr,
    output logic [7:0]  data,
    output logic        last
);

    // Select address and byte for the current step.
    always_comb begin
        addr = ADDR_COUNT;
        data = count_lo;
        unique case (step)
            3'd0: begin addr = ADDR_COUNT; data = count_lo;     end
            3'd1: begin addr = ADDR_LBA0;  data = lba[7:0];     end
            3'd2: begin addr = ADDR_LBA1;  data = lba[15:8];    end
            3'd3: begin addr = ADDR_LBA2;  data = lba[23:16];   end
            3'd4: begin addr = ADDR_DRVHD;
                        data = DRVHD_BASE | {3'b000, drive, lba[27:24]}; end
            3'd5: begin addr = ADDR_CMDST;
                        data = is_write ? CMD_WR_SECT : CMD_RD_SECT; end
            default: begin addr = ADDR_COUNT; data = count_lo; end
        endcase
    end

    assign last = step == 3'd5;

endmodule

// File: rtl/ata_xfer_count.sv
// Word and sector counters for the data phase.
// Assumes load happens only at request accept and step only on a completed data word.
module ata_xfer_count #(
    parameter int WORDS  = 128,
    parameter int CNTW   = 9,
    localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CNTW-1:0] count,
    input  logic            step,
    output logic            last_word,
    output logic            last_sector
);

    logic [WW-1:0]   word_idx;
    logic [CNTW-1:0] sec_left;

    assign last_word   = word_idx == WW'(WORDS - 1);
    assign last_sector = sec_left == CNTW'(1);

    // Advance the word index, wrapping into the next sector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_idx <= '0;
            sec_left <= '0;
        end else if (load) begin
            word_idx <= '0;
            sec_left <= count;
        end else if (step) begin
            if (last_word) begin
                word_idx <= '0;
                sec_left <= sec_left - 1'b1;
            end else begin
                word_idx <= word_idx + 1'b1;
            end
        end
    end

    // R7: data words are only moved while sectors remain.
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> sec_left != '0);

endmodule

// File: rtl/ata_pio_seq.sv
// PIO sector transfer sequencer (top).
// Waits for readiness, programs the task file, then polls and moves each sector.
// Assumes a single-cycle register bus with read data valid in the strobe cycle.
module ata_pio_seq
    import ata_seq_pkg::*;
#(
    parameter int POLL_LIMIT   = 100000,
    parameter int PROBE_LIMIT  = 1000,
    parameter int SECTOR_WORDS = 128,
    parameter int MAX_SECTORS  = 256,
    localparam int CNTW = $clog2(MAX_SECTORS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_op,
    input  logic [27:0]     req_lba,
    input  logic [CNTW-1:0] req_count,
    input  logic            req_drive,
    output logic            done,
    output logic            fail,
    output logic [1:0]      fail_cause,
    output logic            present,
    output logic [3:0]      rb_addr,
    output logic [31:0]     rb_wdata,
    output logic            rb_wr,
    output logic            rb_rd,
    input  logic [31:0]     rb_rdata,
    output logic            rd_valid,
    input  logic            rd_ready,
    output logic [31:0]     rd_data,
    input  logic            wr_valid,
    output logic            wr_ready,
    input  logic [31:0]     wr_data
);

    state_e          state;
    op_e             op_q;
    cause_e          cause_q;
    logic [27:0]     lba_q;
    logic [CNTW-1:0] count_q;
    logic            drive_q;
    logic [2:0]      step_q;
    logic            present_q;
    logic [31:0]     rd_hold;

    logic            poll_rdy, poll_prb;
    logic            rdy_hit, rdy_fault, rdy_exp;
    logic            prb_hit, prb_fault, prb_exp;
    logic [3:0]      enc_addr;
    logic [7:0]      enc_data;
    logic            enc_last;
    logic            word_step, last_word, last_sector;
    logic            accept, bad_req;

    assign accept  = (state == S_IDLE) && req_valid;
    assign bad_req = (req_op == OP_BAD) || (req_count == '0) ||
                     (req_count > CNTW'(MAX_SECTORS));

    ata_status_eval #(.LIMIT(POLL_LIMIT), .MATCH_READY(1'b1)) u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .poll    (poll_rdy),
        .status  (rb_rdata[7:0]),
        .hit     (rdy_hit),
        .fault   (rdy_fault),
        .expired (rdy_exp)
    );

    ata_status_eval #(.LIMIT(PROBE_LIMIT), .MATCH_READY(1'b0)) u_probe (
        .clk     (clk),
        .rst_n   (rst_n),
        .poll    (poll_prb),
        .status  (rb_rdata[7:0]),
        .hit     (prb_hit),
        .fault   (prb_fault),
        .expired (prb_exp)
    );

    ata_taskfile_enc u_enc (
        .step     (step_q),
        .count_lo (count_q[7:0]),
        .lba      (lba_q),
        .drive    (drive_q),
        .is_write (op_q == OP_WRITE),
        .addr     (enc_addr),
        .data     (enc_data),
        .last     (enc_last)
    );

    ata_xfer_count #(.WORDS(SECTOR_WORDS), .CNTW(CNTW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .count       (req_count),
        .step        (word_step),
        .last_word   (last_word),
        .last_sector (last_sector)
    );

    // Drive the register bus, stream handshakes and poll enables from the state.
    always_comb begin
        rb_addr   = ADDR_DATA;
        rb_wdata  = '0;
        rb_wr     = 1'b0;
        rb_rd     = 1'b0;
        wr_ready  = 1'b0;
        poll_rdy  = 1'b0;
        poll_prb  = 1'b0;
        word_step = 1'b0;
        unique case (state)
            S_PREWAIT, S_SECWAIT, S_PRBWAIT: begin
                rb_addr  = ADDR_CMDST;
                rb_rd    = 1'b1;
                poll_rdy = 1'b1;
            end
            S_PRBPOLL: begin
                rb_addr  = ADDR_CMDST;
                rb_rd    = 1'b1;
                poll_prb = 1'b1;
            end
            S_CTRL: begin
                rb_addr = ADDR_DEVCTL;
                rb_wr   = 1'b1;
            end
            S_TASK: begin
                rb_addr  = enc_addr;
                rb_wdata = {24'h0, enc_data};
                rb_wr    = 1'b1;
            end
            S_PRBSEL: begin
                rb_addr  = ADDR_DRVHD;
                rb_wdata = {24'h0, DRVHD_BASE | 8'h10};
                rb_wr    = 1'b1;
            end
            S_PRBDESEL: begin
                rb_addr  = ADDR_DRVHD;
                rb_wdata = {24'h0, DRVHD_BASE};
                rb_wr    = 1'b1;
            end
            S_RDBUS: begin
                rb_addr = ADDR_DATA;
                rb_rd   = 1'b1;
            end
            S_RDOUT: begin
                word_step = rd_ready;
            end
            S_WRXFER: begin
                wr_ready  = 1'b1;
                rb_addr   = ADDR_DATA;
                rb_wdata  = wr_data;
                rb_wr     = wr_valid;
                word_step = wr_valid;
            end
            default: ;
        endcase
    end

    // Sequence the request: accept, wait, program, per-sector poll and transfer, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            op_q      <= OP_READ;
            cause_q   <= CAUSE_NONE;
            lba_q     <= '0;
            count_q   <= '0;
            drive_q   <= 1'b0;
            step_q    <= '0;
            present_q <= 1'b0;
            rd_hold   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q      <= op_e'(req_op);
                    lba_q     <= req_lba;
                    count_q   <= req_count;
                    drive_q   <= req_drive;
                    step_q    <= '0;
                    present_q <= 1'b0;
                    cause_q   <= CAUSE_NONE;
                    if (req_op == OP_PROBE) begin
                        state <= S_PRBWAIT;
                    end else if (bad_req) begin
                        cause_q <= CAUSE_REQUEST;
                        state   <= S_FINISH;
                    end else begin
                        state <= S_PREWAIT;
                    end
                end
                S_PREWAIT: begin
                    if (rdy_hit) begin
                        state <= (op_q == OP_READ) ? S_CTRL : S_TASK;
                    end else if (rdy_exp) begin
                        cause_q <= CAUSE_TIMEOUT;
                        state   <= S_FINISH;
                    end
                end
                S_CTRL: state <= S_TASK;
                S_TASK: begin
                    if (enc_last) begin
                        step_q <= '0;
                        state  <= S_SECWAIT;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                S_SECWAIT: begin
                    if (rdy_hit) begin
                        if (rdy_fault) begin
                            cause_q <= CAUSE_DEVICE;
                            state   <= S_FINISH;
                        end else begin
                            state <= (op_q == OP_READ) ? S_RDBUS : S_WRXFER;
                        end
                    end else if (rdy_exp) begin
                        cause_q <= CAUSE_TIMEOUT;
                        state   <= S_FINISH;
                    end
                end
                S_RDBUS: begin
                    rd_hold <= rb_rdata;
                    state   <= S_RDOUT;
                end
                S_RDOUT: if (rd_ready) begin
                    if (!last_word)       state <= S_RDBUS;
                    else if (last_sector) state <= S_FINISH;
                    else                  state <= S_SECWAIT;
                end
                S_WRXFER: if (wr_valid && last_word) begin
                    state <= last_sector ? S_FINISH : S_SECWAIT;
                end
                S_PRBWAIT: begin
                    if (rdy_hit) begin
                        state <= S_PRBSEL;
                    end else if (rdy_exp) begin
                        cause_q <= CAUSE_TIMEOUT;
                        state   <= S_FINISH;
                    end
                end
                S_PRBSEL: state <= S_PRBPOLL;
                S_PRBPOLL: begin
                    if (prb_hit) begin
                        present_q <= 1'b1;
                        state     <= S_PRBDESEL;
                    end else if (prb_exp) begin
                        state <= S_PRBDESEL;
                    end
                end
                S_PRBDESEL: state <= S_FINISH;
                S_FINISH:   state <= S_IDLE;
                default:    state <= S_IDLE;
            endcase
        end
    end

    assign req_ready  = state == S_IDLE;
    assign done       = state == S_FINISH;
    assign fail       = done && (cause_q != CAUSE_NONE);
    assign fail_cause = cause_q;
    assign present    = present_q;
    assign rd_valid   = state == S_RDOUT;
    assign rd_data    = rd_hold;

    // R3: the command write directly follows the drive/head write.
    assert_cmd_after_drvhd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_wr && rb_addr == ADDR_CMDST) |-> ($past(rb_wr) && $past(rb_addr) == ADDR_DRVHD));

    // R2: the device control write is followed at once by the count write.
    assert_ctrl_then_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_wr && rb_addr == ADDR_DEVCTL) |=> (rb_wr && rb_addr == ADDR_COUNT));

    // R8: a stalled read word holds.
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R13: completion is a single-cycle pulse; an accepted request drops req_ready.
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_accept_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1: the bus never carries a read and a write strobe together.
    assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rb_rd && rb_wr));

endmodule

// File: tb/ata_pio_seq_test.sv
// Bench: a behavioural drive model answers the bus, an expected-access queue built
// from the requirements is compared against every strobe on every clock.
module ata_pio_seq_test;

    localparam int POLL_LIM  = 16;
    localparam int PROBE_LIM = 20;
    localparam logic [31:0] DBASE = 32'hA500_0000;
    localparam logic [31:0] WBASE = 32'h5A00_0000;

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic        chk;
        logic [3:0]  rq;
    } bus_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [27:0] req_lba = '0;
    logic [8:0]  req_count = '0;
    logic        req_drive = 1'b0;
    logic        done, fail, present;
    logic [1:0]  fail_cause;
    logic [3:0]  rb_addr;
    logic [31:0] rb_wdata, rb_rdata;
    logic        rb_wr, rb_rd;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [31:0] rd_data;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_data = '0;

    int checks = 0;
    int fails = 0;
    bus_t exp_q[$];
    logic [7:0] stat_arr [0:4095];
    int stat_len = 0;
    int stat_idx = 0;
    int dev_ridx = 0;
    int got_idx = 0;
    int wr_k = 0;
    int wexp = 0;
    int cyc = 0;
    bit wr_en = 1'b0;
    logic [7:0] stat_cur;

    always #4 clk = ~clk;

    ata_pio_seq #(.POLL_LIMIT(POLL_LIM), .PROBE_LIMIT(PROBE_LIM)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_lba(req_lba), .req_count(req_count), .req_drive(req_drive),
        .done(done), .fail(fail), .fail_cause(fail_cause), .present(present),
        .rb_addr(rb_addr), .rb_wdata(rb_wdata), .rb_wr(rb_wr), .rb_rd(rb_rd),
        .rb_rdata(rb_rdata),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data)
    );

    // Drive model: scripted status bytes, then ready; data words count up.
    assign stat_cur = (stat_idx < stat_len) ? stat_arr[stat_idx] : 8'h40;
    assign rb_rdata = (rb_addr == 4'h7) ? {24'h0, stat_cur} :
                      (rb_addr == 4'h0) ? DBASE + 32'(dev_ridx) : 32'h0;

    always @(posedge clk) begin
        if (rb_rd && rb_addr == 4'h7) stat_idx <= stat_idx + 1;
        if (rb_rd && rb_addr == 4'h0) dev_ridx <= dev_ridx + 1;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    // Stream stimulus, changed just after each rising edge.
    always begin
        @(posedge clk);
        #1;
        cyc++;
        rd_ready = (cyc % 3) != 1;
        wr_valid = wr_en && ((cyc % 4) != 2);
        wr_data  = WBASE + 32'(wr_k);
    end

    // Per-clock comparison of bus strobes and stream words with the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rb_rd || rb_wr) begin
                bus_t e;
                if (rb_rd && rb_wr) chk(1'b0, "R1", "both strobes", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected bus access addr", rb_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rb_wr == e.wr && rb_addr == e.addr, $sformatf("R%0d", e.rq),
                        "bus kind/addr", {rb_wr, rb_addr}, {e.wr, e.addr});
                    if (e.chk && rb_wr)
                        chk(rb_wdata == e.data, $sformatf("R%0d", e.rq), "bus wdata",
                            rb_wdata, e.data);
                end
            end
            if (rd_valid && rd_ready) begin
                chk(rd_data == DBASE + 32'(got_idx), "R8", "read stream word",
                    rd_data, DBASE + 32'(got_idx));
                got_idx++;
            end
            if (wr_valid && wr_ready) wr_k++;
        end
    end

    task automatic push_rd(input logic [3:0] a, input logic [3:0] rq);
        exp_q.push_back({1'b0, a, 32'h0, 1'b0, rq});
    endtask

    task automatic push_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] rq);
        exp_q.push_back({1'b1, a, d, 1'b1, rq});
    endtask

    task automatic stat(input logic [7:0] s, input logic [3:0] rq);
        stat_arr[stat_len] = s;
        stat_len++;
        push_rd(4'h7, rq);
    endtask

    // R2, R3, R4, R5: expected programming sequence.
    task automatic plan_cmd(input bit is_wr, input logic [27:0] lba,
                            input logic [8:0] cnt, input bit drv);
        if (!is_wr) push_wr(4'hE, 32'h0, 4'd2);
        push_wr(4'h2, {24'h0, cnt[7:0]}, 4'd5);
        push_wr(4'h3, {24'h0, lba[7:0]}, 4'd3);
        push_wr(4'h4, {24'h0, lba[15:8]}, 4'd3);
        push_wr(4'h5, {24'h0, lba[23:16]}, 4'd3);
        push_wr(4'h6, {24'h0, 8'hE0 | (8'(drv) << 4) | {4'h0, lba[27:24]}}, 4'd4);
        push_wr(4'h7, is_wr ? 32'h30 : 32'h20, 4'd4);
    endtask

    // R7, R9: 128 data accesses for one sector.
    task automatic plan_sector(input bit is_wr);
        for (int k = 0; k < 128; k++) begin
            if (is_wr) begin
                push_wr(4'h0, WBASE + 32'(wexp), 4'd9);
                wexp++;
            end else begin
                push_rd(4'h0, 4'd7);
            end
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [27:0] lba, input logic [8:0] cnt,
                       input bit drv, input logic [1:0] exp_cause, input bit exp_pres,
                       input string rq);
        bit seen;
        wr_en = (op == 2'd1);
        @(posedge clk); #1;
        req_op = op; req_lba = lba; req_count = cnt; req_drive = drv; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0 || done, "R13", "req_ready while busy", req_ready, 0);
        seen = 1'b0;
        for (int i = 0; i < 40000 && !seen; i++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        chk(seen, rq, "done seen", seen, 1);
        chk(fail_cause == exp_cause, rq, "fail_cause", fail_cause, exp_cause);
        chk(fail == (exp_cause != 2'd0), "R13", "fail flag", fail, exp_cause != 2'd0);
        if (op == 2'd2) chk(present == exp_pres, "R12", "present", present, exp_pres);
        @(negedge clk);
        chk(done == 1'b0, "R13", "done one cycle", done, 0);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, rq, "accesses left unmade", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk(req_ready && !done && !rb_rd && !rb_wr && !rd_valid && !wr_ready, "R13",
            "reset outputs", {req_ready, done, rb_rd, rb_wr, rd_valid, wr_ready}, 6'b100000);

        // R1 R2 R7 R8: read one sector; 0xC0 and 0x00 are not ready.
        stat(8'hC0, 4'd1); stat(8'h00, 4'd1); stat(8'h40, 4'd1);
        plan_cmd(1'b0, 28'h0123456, 9'd1, 1'b0);
        stat(8'h80, 4'd7); stat(8'h58, 4'd7);
        plan_sector(1'b0);
        run(2'd0, 28'h0123456, 9'd1, 1'b0, 2'd0, 1'b0, "R7");
        chk(got_idx == 128, "R8", "words delivered", got_idx, 128);

        // R4 R9: write two sectors to drive 1.
        stat(8'h80, 4'd1); stat(8'h40, 4'd1);
        plan_cmd(1'b1, 28'hABCDEF1, 9'd2, 1'b1);
        stat(8'h80, 4'd7); stat(8'h80, 4'd7); stat(8'h40, 4'd7);
        plan_sector(1'b1);
        stat(8'h50, 4'd7);
        plan_sector(1'b1);
        run(2'd1, 28'hABCDEF1, 9'd2, 1'b1, 2'd0, 1'b0, "R9");
        chk(wr_k == 256, "R9", "words consumed", wr_k, 256);

        // R10: DF ignored before command; ERR at second sector aborts.
        stat(8'h80, 4'd10); stat(8'h61, 4'd10);
        plan_cmd(1'b1, 28'h0000010, 9'd3, 1'b0);
        stat(8'h40, 4'd7);
        plan_sector(1'b1);
        stat(8'h80, 4'd10); stat(8'h41, 4'd10);
        run(2'd1, 28'h0000010, 9'd3, 1'b0, 2'd1, 1'b0, "R10");

        // R5 R10: 256 sectors encode as 0x00; DF at first sector aborts the read.
        stat(8'h40, 4'd1);
        plan_cmd(1'b0, 28'h7654321, 9'd256, 1'b1);
        stat(8'h60, 4'd10);
        run(2'd0, 28'h7654321, 9'd256, 1'b1, 2'd1, 1'b0, "R5");

        // R6: rejected requests make no bus access.
        run(2'd0, 28'h1, 9'd257, 1'b0, 2'd3, 1'b0, "R6");
        run(2'd1, 28'h1, 9'd0,   1'b0, 2'd3, 1'b0, "R6");
        run(2'd3, 28'h1, 9'd4,   1'b0, 2'd3, 1'b0, "R6");

        // R11: POLL_LIMIT busy reads time out.
        for (int i = 0; i < POLL_LIM; i++) stat(8'h80, 4'd11);
        run(2'd0, 28'h2, 9'd1, 1'b0, 2'd2, 1'b0, "R11");

        // R12: probe finds drive 1 on the third read.
        stat(8'h50, 4'd12);
        push_wr(4'h6, 32'hF0, 4'd12);
        stat(8'h00, 4'd12); stat(8'h00, 4'd12); stat(8'h50, 4'd12);
        push_wr(4'h6, 32'hE0, 4'd12);
        run(2'd2, 28'h0, 9'd0, 1'b0, 2'd0, 1'b1, "R12");

        // R12: probe sees only zeros for PROBE_LIMIT reads.
        stat(8'h40, 4'd12);
        push_wr(4'h6, 32'hF0, 4'd12);
        for (int i = 0; i < PROBE_LIM; i++) stat(8'h00, 4'd12);
        push_wr(4'h6, 32'hE0, 4'd12);
        run(2'd2, 28'h0, 9'd0, 1'b0, 2'd0, 1'b0, "R12");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R13: watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule